// File: doc/BRIEF.md
# Mailbox interrupt status controller

This block is the interrupt status and enable register pair of a bus-bridge target. One 32-bit status word holds two kinds of source. Four live error bits show the error flags kept in the configuration status register; they are read-only here. Eight event bits each latch when the local side writes one of eight inbound mailboxes, and stay set until software writes a one to them.

A second 32-bit word is the enable mask. It lines up bit for bit with the status word. The single active-high interrupt request is a registered OR of every status bit whose enable bit is set.

The register port is plain: one address, a write strobe, write data, and read data that follows the address in the same cycle. Every access is accepted in the cycle it is presented. There is no back-pressure and no handshake. The eight mailbox strobes and the four error inputs are plain level or pulse pins.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: A high on `mbox_wr[i]` sets status bit 16+i at the next clock edge, for i from 0 to 7. The bit reads as 1 at offset 0x40 from that edge on.
- R2: A write to offset 0x40 clears each event bit 16..23 whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R3: If a mailbox strobe and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R4: Status bits 10, 11, 12 and 13 read the current levels of `cfg_err[0]` (target abort received), `cfg_err[1]` (master abort received), `cfg_err[2]` (system error signaled) and `cfg_err[3]` (parity error detected). There is no added delay.
- R5: Writes to offset 0x40 have no effect on bits 10..13. Those bits fall only when the matching `cfg_err` input falls.
- R6: In both registers, bits 0..9, 14, 15 and 24..31 always read 0, and writes to them are ignored.
- R7: A write to offset 0x50 loads the enable bits 10..13 and 16..23 from the write data. Reading offset 0x50 returns those bits.
- R8: When any status bit is 1 and its enable bit is 1, `irq` is 1 from the following clock edge.
- R9: `irq` goes to 0 at the clock edge after the last enabled status bit clears or loses its enable.
- R10: A synchronous reset clears all event bits and all enable bits, and drives `irq` to 0.
- R11: At any address other than 0x40 and 0x50, reads return 0 and writes change no state. Addresses are byte offsets, and only whole 32-bit words are accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mbox_wr | input | 8 | One strobe per inbound mailbox write |
| cfg_err | input | 4 | Error flags from the configuration status register |
| irq | output | 1 | Interrupt request, active high, registered |

## Verification
The bench first drives a mailbox strobe and a clearing write onto the same bit in one cycle. A design that lets the clear win would read 0 there and drop the event. It also writes all ones to the status word while the error inputs are high. A design that stored or cleared the mirrored bits would then show 0 while the error is still present.

The timing of `irq` is checked on every clock against a behavioural model. This catches a request that is one cycle early or late, that ignores the mask, or that stays high after its enable is removed. Writes of all ones to reserved bits and to unused offsets must leave both read-back words exact. A mid-run reset with events and enables set must empty both words.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int REG_W    = 32;
  localparam int ERR_LSB  = 10;
  localparam int N_ERR    = 4;
  localparam int MBOX_LSB = 16;
  localparam int N_MBOX   = 8;

  localparam logic [REG_W-1:0] ERR_MASK  = ((REG_W'(1) << N_ERR) - REG_W'(1)) << ERR_LSB;
  localparam logic [REG_W-1:0] MBOX_MASK = ((REG_W'(1) << N_MBOX) - REG_W'(1)) << MBOX_LSB;
  localparam logic [REG_W-1:0] LIVE_MASK = ERR_MASK | MBOX_MASK;
endpackage

// File: rtl/mbox_evt_latch.sv
module mbox_evt_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           stat_o[i] <= 1'b0;
      else if (set_i[i]) stat_o[i] <= 1'b1;   // set has priority over clear
      else if (clr_i[i]) stat_o[i] <= 1'b0;
    end

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> stat_o[i]);
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
      (set_i[i] && clr_i[i]) |=> stat_o[i]);
    assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !stat_o[i]);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_i[i]) |=> $stable(stat_o[i]));
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst)       en_o <= '0;
    else if (wr_i) en_o <= wdata_i & MASK;
  end

  assert_en_reset_R10: assert property (@(posedge clk)
    rst |=> (en_o == '0));
  assert_en_rsvd_R6: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> ((en_o & ~MASK) == '0));
  assert_en_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat_i & en_i);
  end

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (|(stat_i & en_i)) |=> irq_o);
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] EN_OFS   = 8'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [N_MBOX-1:0] mbox_wr,
  input  logic [N_ERR-1:0]  cfg_err,
  output logic              irq
);
  logic              stat_hit, en_hit;
  logic [N_MBOX-1:0] evt_clr, evt_stat;
  logic [REG_W-1:0]  stat_view, en_q;

  assign stat_hit = (reg_addr == STAT_OFS);
  assign en_hit   = (reg_addr == EN_OFS);
  assign evt_clr  = (reg_wr && stat_hit) ? reg_wdata[MBOX_LSB +: N_MBOX] : '0;

  mbox_evt_latch #(.N(N_MBOX)) u_evt (
    .clk(clk), .rst(rst), .set_i(mbox_wr), .clr_i(evt_clr), .stat_o(evt_stat)
  );

  irq_en_reg #(.W(REG_W), .MASK(LIVE_MASK)) u_en (
    .clk(clk), .rst(rst), .wr_i(reg_wr && en_hit), .wdata_i(reg_wdata), .en_o(en_q)
  );

  always_comb begin
    stat_view = '0;
    stat_view[ERR_LSB +: N_ERR]   = cfg_err;
    stat_view[MBOX_LSB +: N_MBOX] = evt_stat;
  end

  irq_combine #(.W(REG_W)) u_irq (
    .clk(clk), .rst(rst), .stat_i(stat_view), .en_i(en_q), .irq_o(irq)
  );

  always_comb begin
    if (stat_hit)    reg_rdata = stat_view;
    else if (en_hit) reg_rdata = en_q;
    else             reg_rdata = '0;
  end

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~LIVE_MASK) == '0);
  assert_other_addr_R11: assert property (@(posedge clk) disable iff (rst)
    (!stat_hit && !en_hit) |-> (reg_rdata == '0));
endmodule

// File: tb/mbox_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  mbox_wr;
  logic [3:0]  cfg_err;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;
  string cur_req = "R10";

  // behavioural reference state
  bit [7:0]  m_evt;
  bit [31:0] m_en;
  bit        m_irq;

  always #2.5 clk = ~clk;

  mbox_irq_ctrl u_mbox_irq_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mbox_wr(mbox_wr),
    .cfg_err(cfg_err), .irq(irq)
  );

  function automatic bit [31:0] m_status();
    return {8'h00, m_evt, 2'b00, cfg_err, 10'h000};
  endfunction

  function automatic bit [31:0] m_read(input bit [7:0] a);
    if (a == 8'h40) return m_status();
    if (a == 8'h50) return m_en;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    bit [31:0] st;
    st = m_status();
    if (rst) begin
      m_evt = '0; m_en = '0; m_irq = 0;
    end else begin
      m_irq = ((st & m_en) != 0);
      for (int i = 0; i < 8; i++) begin
        if (mbox_wr[i]) m_evt[i] = 1;
        else if (reg_wr && reg_addr == 8'h40 && reg_wdata[16+i]) m_evt[i] = 0;
      end
      if (reg_wr && reg_addr == 8'h50) m_en = reg_wdata & 32'h00FF3C00;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input bit [7:0] a, input bit [31:0] d,
                     input bit [7:0] mb, input bit [3:0] e);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; mbox_wr = mb; cfg_err = e;
    #1;
    if (!rst) begin
      check(cur_req, "irq", {31'b0, irq}, {31'b0, m_irq});
      check(cur_req, "rdata", reg_rdata, m_read(a));
    end
  endtask

  task automatic rd(input bit [7:0] a, input bit [3:0] e);
    cyc(0, a, 32'h0, 8'h00, e);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; mbox_wr = 0; cfg_err = 0;
    repeat (3) @(negedge clk);
    @(negedge clk); rst = 0;
    cur_req = "R10";
    rd(8'h40, 0); check("R10", "status after reset", reg_rdata, 32'h0);
    rd(8'h50, 0); check("R10", "enable after reset", reg_rdata, 32'h0);
    check("R10", "irq after reset", {31'b0, irq}, 32'h0);

    cur_req = "R7";
    cyc(1, 8'h50, 32'hFFFF_FFFF, 0, 0);
    rd(8'h50, 0); check("R7", "enable readback", reg_rdata, 32'h00FF3C00);
    cur_req = "R6";
    check("R6", "enable reserved bits", reg_rdata & 32'hFF00C3FF, 32'h0);

    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin
      cyc(0, 8'h40, 0, 8'(1 << i), 0);
      rd(8'h40, 0);
      check("R1", "event bit set", reg_rdata, 32'h1 << 16 << i | ((32'h1 << 16 << i) - 32'h10000));
    end
    cur_req = "R8";
    rd(8'h40, 0);
    check("R8", "irq with enabled events", {31'b0, irq}, 32'h1);

    cur_req = "R2";
    cyc(1, 8'h40, 32'h0001_0000, 0, 0);
    rd(8'h40, 0); check("R2", "clear bit 16 only", reg_rdata, 32'h00FE0000);
    cyc(1, 8'h40, 32'h0000_0000, 0, 0);
    rd(8'h40, 0); check("R2", "write zero keeps", reg_rdata, 32'h00FE0000);

    cur_req = "R3";
    cyc(1, 8'h40, 32'h0004_0000, 8'h04, 0);
    rd(8'h40, 0); check("R3", "set wins over clear", reg_rdata, 32'h00FE0000);

    cur_req = "R9";
    cyc(1, 8'h40, 32'h00FF_0000, 0, 0);
    rd(8'h40, 0); check("R9", "all events cleared", reg_rdata, 32'h0);
    rd(8'h40, 0); check("R9", "irq low after clear", {31'b0, irq}, 32'h0);

    cur_req = "R4";
    for (int k = 0; k < 4; k++) begin
      rd(8'h40, 4'(1 << k));
      check("R4", "mirror bit", reg_rdata, 32'h400 << k);
    end
    rd(8'h40, 4'hF); rd(8'h40, 4'hF);
    check("R8", "irq from mirrored error", {31'b0, irq}, 32'h1);

    cur_req = "R5";
    cyc(1, 8'h40, 32'hFFFF_FFFF, 0, 4'hF);
    rd(8'h40, 4'hF); check("R5", "mirror survives write", reg_rdata, 32'h00003C00);
    rd(8'h40, 4'h5); check("R5", "mirror follows input", reg_rdata, 32'h00001400);

    cur_req = "R9";
    cyc(1, 8'h50, 32'h0000_0000, 0, 4'h5);
    rd(8'h50, 4'h5); rd(8'h50, 4'h5);
    check("R9", "irq low after enable removed", {31'b0, irq}, 32'h0);

    cur_req = "R11";
    cyc(1, 8'h44, 32'hFFFF_FFFF, 0, 0);
    cyc(1, 8'h54, 32'hFFFF_FFFF, 0, 0);
    rd(8'h44, 0); check("R11", "unused offset reads 0", reg_rdata, 32'h0);
    rd(8'h50, 0); check("R11", "enable untouched", reg_rdata, 32'h0);

    cur_req = "R10";
    cyc(1, 8'h50, 32'h00FF_3C00, 8'hA5, 0);
    rd(8'h40, 0); rd(8'h40, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(8'h40, 0); check("R10", "status after mid reset", reg_rdata, 32'h0);
    rd(8'h50, 0); check("R10", "enable after mid reset", reg_rdata, 32'h0);
    check("R10", "irq after mid reset", {31'b0, irq}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule